// File: doc/BRIEF.md
# Prescaled Timer with Compare Clear

This block is a 16-bit timer/counter whose count advances only on ticks from a built-in clock prescaler. A 3-bit clock-select input picks the tick rate: stopped, every system clock, or one tick every 8, 64, 256 or 1024 system clocks. Because the prescaler runs freely, every count value lasts one full prescale period. That includes a value reached by a clear.

There are two modes. In normal mode the counter counts upward. When the clear-on-compare input is set, the count returns to zero on the tick after it equals compare value A. In PWM mode the same input selects the counting shape. When it is clear, the counter counts up to a TOP value and then back down to zero, and repeats. When it is set, the counter counts up to TOP and then wraps to zero, giving a sawtooth. A one-clock compare-match pulse marks the first system clock in which the count equals compare value A.

Top module: `ptc_timer`

## Requirements
- R1: A synchronous active-high reset sets the count to 0, holds the match pulse low, clears the prescaler and sets the up/down direction to up.
- R2: Clock-select code 000 stops the counter, and so do codes 110 and 111. The stopped count holds its value.
- R3: Clock-select codes 001, 010, 011, 100 and 101 give one count tick every 1, 8, 64, 256 and 1024 system clocks. The prescaler runs freely from reset, and the count changes only on a tick, so every value is held for the full period.
- R4: In normal mode (pwm_mode=0) with clear_on_match=0, each tick adds one to the count. A compare match does not alter the counting, and 0xFFFF wraps to 0.
- R5: In normal mode with clear_on_match=1, a tick taken while the count equals cmp_a loads 0. The sequence is cmp_a-1, cmp_a, 0, 1.
- R6: In PWM mode with clear_on_match=1, a tick taken while the count is at or above top_val loads 0. Any other tick adds one.
- R7: In PWM mode with clear_on_match=0, the counter counts up to top_val and then down to 0, and repeats. The direction reverses at both ends, so each end value lasts a single tick. A tick at 0 always moves to 1. When top_val is 0, the count stays at 0.
- R8: match_pulse is high for the one system clock that follows a tick whose new count equals cmp_a, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Prescale select (000 stop, 001 /1, 010 /8, 011 /64, 100 /256, 101 /1024, others stop) |
| clear_on_match | input | 1 | Normal mode: clear after a compare A match; PWM mode: 1 wrap, 0 up/down |
| pwm_mode | input | 1 | 1 selects PWM counting |
| cmp_a | input | 16 | Compare value A |
| top_val | input | 16 | TOP value for PWM mode |
| count | output | 16 | Current counter value |
| match_pulse | output | 1 | One-clock compare A match pulse |

## Verification
A wrong prescaler phase shows up at once as a count that changes a few system clocks early or late relative to the free-running division. The bench compares the count on every clock, so the fault is caught within one prescale period. A wrong direction bit in up/down mode shows at the next tick after an end value, as a repeated TOP or 0, or as a count that runs past TOP. A clear that comes late or early shows as cmp_a held for two periods or skipped. A bad match pulse shows in the same clock as the count it should mark.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int CNT_W   = 16;
    localparam int PRE_W   = 10;
    localparam int SEL_W   = 3;
    localparam int NUM_DIV = 5;
    localparam int NUM_SEL = 2 ** SEL_W;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_CLEAR  = 2'd1,
        MODE_WRAP   = 2'd2,
        MODE_UPDOWN = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             up;
    } cnt_state_t;

    // log2 of the division for prescale choice idx (0 -> /1 ... 4 -> /1024)
    function automatic int div_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic cnt_mode_e decode_mode(input logic pwm, input logic clr);
        if (!pwm) return clr ? MODE_CLEAR : MODE_FREE;
        return clr ? MODE_WRAP : MODE_UPDOWN;
    endfunction

endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler
    import ptc_pkg::*;
#(
    parameter int P_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [P_W-1:0]     pre_q;
    logic [NUM_SEL-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + P_W'(1);
    end

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
        if (i >= 1 && i <= NUM_DIV) begin : g_div
            localparam int SH = div_shift(i - 1);
            localparam logic [P_W-1:0] MASK = (P_W'(1) << SH) - P_W'(1);
            assign taps[i] = ((pre_q & MASK) == MASK);
        end else begin : g_stop
            assign taps[i] = 1'b0;
        end
    end

    assign tick = taps[sel];

endmodule

// File: rtl/ptc_core.sv
module ptc_core
    import ptc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    output logic [W-1:0] value,
    output logic [W-1:0] value_next
);
    cnt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            case (mode)
                MODE_FREE:  st_d.value = st_q.value + W'(1);
                MODE_CLEAR: st_d.value = (st_q.value == cmp) ? '0 : st_q.value + W'(1);
                MODE_WRAP:  st_d.value = (st_q.value >= top) ? '0 : st_q.value + W'(1);
                default: begin
                    if (top == '0) begin
                        st_d.value = '0;
                        st_d.up    = 1'b1;
                    end else if (st_q.up) begin
                        if (st_q.value >= top) begin
                            st_d.value = st_q.value - W'(1);
                            st_d.up    = 1'b0;
                        end else begin
                            st_d.value = st_q.value + W'(1);
                        end
                    end else begin
                        if (st_q.value == '0) begin
                            st_d.value = W'(1);
                            st_d.up    = 1'b1;
                        end else begin
                            st_d.value = st_q.value - W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.value <= '0;
            st_q.up    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign value      = st_q.value;
    assign value_next = st_d.value;

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(value));

    assert_clear_after_match_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_CLEAR && value == cmp) |=> (value == '0));

    assert_wrap_at_top_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_WRAP && value >= top) |=> (value == '0));

    assert_bottom_turns_up_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MODE_UPDOWN && value == '0 && top != '0) |=> (value == W'(1)));

endmodule

// File: rtl/ptc_match.sv
module ptc_match
    import ptc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] next_value,
    input  logic [W-1:0] cmp,
    output logic         pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= tick && (next_value == cmp);
    end
endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
    import ptc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             clear_on_match,
    input  logic             pwm_mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             match_pulse
);
    logic             tick;
    logic [CNT_W-1:0] cnt_next;
    cnt_mode_e        mode;

    assign mode = decode_mode(pwm_mode, clear_on_match);

    ptc_prescaler #(.P_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel),
        .tick (tick)
    );

    ptc_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .mode       (mode),
        .cmp        (cmp_a),
        .top        (top_val),
        .value      (count),
        .value_next (cnt_next)
    );

    ptc_match #(.W(CNT_W)) u_match (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .next_value (cnt_next),
        .cmp        (cmp_a),
        .pulse      (match_pulse)
    );

    assert_pulse_marks_compare_R8: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (count == $past(cmp_a)));

    assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'b000 || clk_sel >= 3'b110) |=> $stable(count));

endmodule

// File: tb/ptc_timer_bench.sv
module ptc_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  clk_sel = 3'b000;
    logic        clear_on_match = 1'b0;
    logic        pwm_mode = 1'b0;
    logic [15:0] cmp_a = 16'd0;
    logic [15:0] top_val = 16'd0;
    logic [15:0] count;
    logic        match_pulse;

    int checks = 0;
    int fails  = 0;
    bit checking = 1'b0;
    string tag = "R1";

    // reference state
    logic [9:0]  m_pre;
    logic [15:0] m_cnt;
    logic        m_up;
    logic        m_match;

    always #2.5 clk = ~clk;

    ptc_timer u_ptc_timer (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .clear_on_match(clear_on_match),
        .pwm_mode(pwm_mode), .cmp_a(cmp_a), .top_val(top_val),
        .count(count), .match_pulse(match_pulse)
    );

    function automatic bit ref_tick(input logic [2:0] s, input logic [9:0] p);
        logic [9:0] m;
        case (s)
            3'b001:  m = 10'h000;
            3'b010:  m = 10'h007;
            3'b011:  m = 10'h03F;
            3'b100:  m = 10'h0FF;
            3'b101:  m = 10'h3FF;
            default: return 1'b0;
        endcase
        return (p & m) == m;
    endfunction

    always @(posedge clk) begin
        logic [15:0] n;
        logic        u;
        if (rst) begin
            m_pre <= '0; m_cnt <= '0; m_up <= 1'b1; m_match <= 1'b0;
        end else begin
            m_pre <= m_pre + 10'd1;
            n = m_cnt; u = m_up;
            if (ref_tick(clk_sel, m_pre)) begin
                if (!pwm_mode && !clear_on_match)      n = m_cnt + 16'd1;
                else if (!pwm_mode)                    n = (m_cnt == cmp_a) ? 16'd0 : m_cnt + 16'd1;
                else if (clear_on_match)               n = (m_cnt >= top_val) ? 16'd0 : m_cnt + 16'd1;
                else if (top_val == 16'd0)             begin n = 16'd0; u = 1'b1; end
                else if (m_up && m_cnt >= top_val)     begin n = m_cnt - 16'd1; u = 1'b0; end
                else if (m_up)                         n = m_cnt + 16'd1;
                else if (m_cnt == 16'd0)               begin n = 16'd1; u = 1'b1; end
                else                                   n = m_cnt - 16'd1;
                m_match <= (n == cmp_a);
            end else begin
                m_match <= 1'b0;
            end
            m_cnt <= n; m_up <= u;
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            checks++;
            if (count !== m_cnt) begin
                fails++;
                $display("FAIL %s count actual=%0d expected=%0d t=%0t", tag, count, m_cnt, $time);
            end
            checks++;
            if (match_pulse !== m_match) begin
                fails++;
                $display("FAIL R8 match_pulse actual=%0b expected=%0b t=%0t", match_pulse, m_match, $time);
            end
        end
    end

    task automatic do_reset();
        checking = 1'b0;
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        checks++;
        if (count !== 16'd0 || match_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%0d/%0b expected=0/0", count, match_pulse);
        end
        checking = 1'b1;
    endtask

    task automatic run(input string t, input logic [2:0] s, input bit pwm, input bit clr,
                       input logic [15:0] c, input logic [15:0] tp, input int cyc);
        @(negedge clk);
        tag = t; clk_sel = s; pwm_mode = pwm; clear_on_match = clr; cmp_a = c; top_val = tp;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        #(5ns * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        do_reset();                                        // R1
        run("R2", 3'b000, 0, 0, 16'd3, 16'd0, 50);         // stopped
        run("R4", 3'b001, 0, 0, 16'd10, 16'd0, 40);        // match has no effect
        run("R2", 3'b110, 0, 0, 16'd10, 16'd0, 30);
        run("R2", 3'b111, 0, 1, 16'd10, 16'd0, 30);
        run("R3", 3'b010, 0, 1, 16'd4, 16'd0, 200);        // /8 with clear
        run("R3", 3'b011, 0, 0, 16'd0, 16'd0, 700);
        run("R3", 3'b100, 1, 1, 16'd2, 16'd3, 2100);
        run("R3", 3'b101, 1, 0, 16'd1, 16'd2, 4300);
        do_reset();
        run("R5", 3'b001, 0, 1, 16'd7, 16'd0, 60);         // C-1, C, 0, 1
        run("R5", 3'b001, 0, 1, 16'd0, 16'd0, 20);         // compare at zero
        do_reset();
        run("R6", 3'b001, 1, 1, 16'd5, 16'd9, 60);
        run("R6", 3'b001, 1, 1, 16'd0, 16'd0, 20);
        do_reset();
        run("R7", 3'b001, 1, 0, 16'd5, 16'd5, 60);         // ends held one tick
        run("R7", 3'b010, 1, 0, 16'd1, 16'd1, 100);
        run("R7", 3'b001, 1, 0, 16'd0, 16'd0, 20);         // TOP of zero
        do_reset();
        run("R4", 3'b001, 0, 0, 16'd65535, 16'd0, 65545);  // wrap through 0xFFFF
        for (int k = 0; k < 40; k++) begin
            logic [2:0] s;
            bit p, c;
            string t;
            s = 3'($urandom_range(0, 7));
            if (s > 3'd3) s = 3'b001;
            p = 1'($urandom);
            c = 1'($urandom);
            t = !p ? (c ? "R5" : "R4") : (c ? "R6" : "R7");
            if (s == 3'b000) t = "R2";
            if (k % 10 == 9) do_reset();
            run(t, s, p, c, 16'($urandom_range(0, 30)), 16'($urandom_range(0, 30)),
                $urandom_range(50, 400));
        end
        checking = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule